// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps a multiplexed-address DRAM refreshed. An interval timer marks each refresh slot. When a slot comes due the block raises a request toward the access arbiter. Once the arbiter grants the bus, the block drives its own strobe sequence onto the memory pins. While the grant is low, the pins simply carry the arbiter's access signals.

Two strobe orderings are available, picked per sequence by a mode input.

- In CAS-first mode, both column strobes fall before the row strobe, and the device's internal counter picks the row.
- In row-strobe-only mode, the column strobes stay high and the block presents a row address from its own counter. That counter wraps at a row count selected by configuration.

Slots that are not granted in time are counted, up to a cap, and then issued back to back. A separate low-power request puts the device into self refresh. It is entered with the CAS-first ordering and held until the request is withdrawn.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it is released, `ref_req` is low, no refresh is pending, and the row counter is 0.
- R2: With no refresh issued, `ref_req` rises exactly INTERVAL clock edges after reset is released, and not one edge earlier.
- R3: No refresh strobe reaches the pins while `ref_gnt` is low. Once a sequence has started, `ref_req` stays high until it ends.
- R4: In CAS-first mode (`cfg_ras_only`=0), a sequence starts one edge after a grant with work pending. It holds both CAS low with RAS high for T_CSR cycles, then RAS low with both CAS low for T_RAS cycles, then all strobes high for T_RP cycles. WE is high and `addr` is 0 throughout.
- R5: In row-only mode (`cfg_ras_only`=1), both CAS stay high and WE stays high. `addr` carries the current row for T_CSR cycles with RAS high, then for T_RAS cycles with RAS low. After that all strobes are high with `addr`=0 for T_RP cycles.
- R6: The row counter advances by one after each row-only sequence and wraps at 2^W rows. W is ROW_W when `cfg_rows`=0, ROW_W-1 when it is 1, and ROW_W-2 when it is 2 or 3. CAS-first sequences leave the counter unchanged.
- R7: Ungranted slots accumulate up to MAX_PEND; further slots are dropped. When granted, the pending sequences run with exactly one idle cycle between them, so one starts every T_CSR+T_RAS+T_RP+1 cycles.
- R8: If nothing more is pending, `ref_req` is low in the cycle right after the last precharge cycle, with all strobes high.
- R9: `dq_oe` is low whenever `ref_gnt` is high, so the data pins stay in high impedance.
- R10: A `self_ref_req` under grant holds both CAS low for T_CSR cycles, then holds RAS and both CAS low for as long as the request stays high. After the request drops, all strobes are high for T_RP cycles. Pending slots are cleared and the timer is held during self refresh, so `ref_req` is low afterwards.
- R11: While `ref_gnt` is low, `ras_n`, `lcas_n`, `ucas_n`, `we_n`, `dq_oe` and `addr` equal the matching `acc_*` inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ras_only | input | 1 | 1 selects row-only refresh, 0 selects CAS-first refresh |
| cfg_rows | input | 2 | Row count select: 0 gives 2^ROW_W rows, 1 gives half that, 2 or 3 gives a quarter |
| self_ref_req | input | 1 | Request to enter and stay in self refresh |
| ref_req | output | 1 | Refresh request toward the arbiter |
| ref_gnt | input | 1 | Grant from the arbiter; the pins belong to this block while it is high |
| acc_ras_n | input | 1 | Access-side row strobe |
| acc_lcas_n | input | 1 | Access-side lower column strobe |
| acc_ucas_n | input | 1 | Access-side upper column strobe |
| acc_we_n | input | 1 | Access-side write enable |
| acc_dq_oe | input | 1 | Access-side data driver enable |
| acc_addr | input | ROW_W | Access-side address |
| ras_n | output | 1 | Row strobe to the DRAM |
| lcas_n | output | 1 | Lower column strobe to the DRAM |
| ucas_n | output | 1 | Upper column strobe to the DRAM |
| we_n | output | 1 | Write enable to the DRAM |
| dq_oe | output | 1 | Data driver enable |
| addr | output | ROW_W | Multiplexed address to the DRAM |

## Verification
The pin multiplexer is combinational, so a change on `ref_gnt` or an `acc_*` input is visible in the same cycle. The timer raises `ref_req` on the INTERVAL-th edge after reset, and a granted sequence shows its first strobe level one edge after the grant. Each later phase follows T_CSR, T_RAS and T_RP edges apart, and `ref_req` falls one edge after the last precharge cycle. The bench samples on the falling clock edge and counts those edges from a known starting point before each comparison. Back-to-back sequences are checked by measuring the edge count between RAS falls, and row wrap is checked by comparing the row address at each RAS fall against a running index.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W    = 13,
  parameter int INTERVAL = 1950,
  parameter int T_CSR    = 2,
  parameter int T_RAS    = 6,
  parameter int T_RP     = 4,
  parameter int MAX_PEND = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ras_only,
  input  logic [1:0]       cfg_rows,
  input  logic             self_ref_req,
  output logic             ref_req,
  input  logic             ref_gnt,
  input  logic             acc_ras_n,
  input  logic             acc_lcas_n,
  input  logic             acc_ucas_n,
  input  logic             acc_we_n,
  input  logic             acc_dq_oe,
  input  logic [ROW_W-1:0] acc_addr,
  output logic             ras_n,
  output logic             lcas_n,
  output logic             ucas_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic [ROW_W-1:0] addr
);
  localparam int TW   = $clog2(INTERVAL + 1);
  localparam int PW   = $clog2(MAX_PEND + 1);
  localparam int MT1  = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int MAXT = (MT1 > T_RP) ? MT1 : T_RP;
  localparam int SW   = $clog2(MAXT + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACT, S_SELF, S_PRE} st_t;

  st_t             state;
  logic [SW-1:0]   stc;
  logic [TW-1:0]   tmr;
  logic [PW-1:0]   pend, pend_nx;
  logic [ROW_W-1:0] row, mask;
  logic            seq_ro, seq_self;
  logic            tick, done, pre_last;

  assign mask     = {ROW_W{1'b1}} >> ((cfg_rows == 2'd0) ? 2'd0 : (cfg_rows == 2'd1) ? 2'd1 : 2'd2);
  assign tick     = (state != S_SELF) && (tmr == TW'(INTERVAL - 1));
  assign pre_last = (state == S_PRE) && (stc == SW'(T_RP - 1));
  assign done     = pre_last && !seq_self;
  assign ref_req  = (pend != '0) || self_ref_req || (state != S_IDLE);

  always_comb begin
    pend_nx = pend - PW'(done);
    if (tick && pend_nx != PW'(MAX_PEND)) pend_nx = pend_nx + 1'b1;
    if (state == S_SELF) pend_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      stc      <= '0;
      tmr      <= '0;
      pend     <= '0;
      row      <= '0;
      seq_ro   <= 1'b0;
      seq_self <= 1'b0;
    end else begin
      tmr  <= (state == S_SELF || tick) ? '0 : tmr + 1'b1;
      pend <= pend_nx;
      stc  <= stc + 1'b1;
      case (state)
        S_IDLE: begin
          stc <= '0;
          if (ref_gnt && (self_ref_req || pend != '0)) begin
            state    <= S_SETUP;
            seq_self <= self_ref_req;
            seq_ro   <= cfg_ras_only && !self_ref_req;
          end
        end
        S_SETUP:
          if (stc == SW'(T_CSR - 1)) begin
            state <= seq_self ? S_SELF : S_ACT;
            stc   <= '0;
          end
        S_ACT:
          if (stc == SW'(T_RAS - 1)) begin
            state <= S_PRE;
            stc   <= '0;
          end
        S_SELF: begin
          stc <= '0;
          if (!self_ref_req) state <= S_PRE;
        end
        S_PRE:
          if (pre_last) begin
            state <= S_IDLE;
            stc   <= '0;
            if (seq_ro) row <= (row + 1'b1) & mask;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic r_ras, r_cas;
  logic [ROW_W-1:0] r_addr;
  assign r_ras  = !(state == S_ACT || state == S_SELF);
  assign r_cas  = !((state == S_SETUP || state == S_ACT || state == S_SELF) && !seq_ro);
  assign r_addr = (seq_ro && (state == S_SETUP || state == S_ACT)) ? (row & mask) : '0;

  assign ras_n  = ref_gnt ? r_ras  : acc_ras_n;
  assign lcas_n = ref_gnt ? r_cas  : acc_lcas_n;
  assign ucas_n = ref_gnt ? r_cas  : acc_ucas_n;
  assign we_n   = ref_gnt ? 1'b1   : acc_we_n;
  assign dq_oe  = ref_gnt ? 1'b0   : acc_dq_oe;
  assign addr   = ref_gnt ? r_addr : acc_addr;
endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
  parameter int ROW_W    = 13,
  parameter int PW       = 4,
  parameter int MAX_PEND = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic [PW-1:0]    pend,
  input logic             acc_ras_n,
  input logic             acc_lcas_n,
  input logic             acc_ucas_n,
  input logic             acc_we_n,
  input logic             acc_dq_oe,
  input logic [ROW_W-1:0] acc_addr,
  input logic             ras_n,
  input logic             lcas_n,
  input logic             ucas_n,
  input logic             we_n,
  input logic             dq_oe,
  input logic [ROW_W-1:0] addr
);
  assert_hiz_under_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> !dq_oe);

  assert_pass_through_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_gnt |-> (ras_n == acc_ras_n && lcas_n == acc_lcas_n && ucas_n == acc_ucas_n &&
                  we_n == acc_we_n && dq_oe == acc_dq_oe && addr == acc_addr));

  assert_cas_first_we_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt && !ras_n && !lcas_n) |-> we_n);

  assert_cas_pair_at_ras_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt && $past(ref_gnt) && $fell(ras_n)) |-> (lcas_n == ucas_n));

  assert_pending_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(MAX_PEND));

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt && !ras_n) |=> ref_req);

  assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt && $fell(ref_req)) |-> (ras_n && lcas_n && ucas_n));
endmodule

bind dram_refresh_sched ref_sched_chk #(.ROW_W(ROW_W), .PW(PW), .MAX_PEND(MAX_PEND)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req), .pend(pend),
  .acc_ras_n(acc_ras_n), .acc_lcas_n(acc_lcas_n), .acc_ucas_n(acc_ucas_n),
  .acc_we_n(acc_we_n), .acc_dq_oe(acc_dq_oe), .acc_addr(acc_addr),
  .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n), .we_n(we_n), .dq_oe(dq_oe), .addr(addr));

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
  localparam int ROW_W = 8, INTERVAL = 200, T_CSR = 2, T_RAS = 4, T_RP = 3, MAX_PEND = 8;
  localparam int SEQ = T_CSR + T_RAS + T_RP + 1;

  logic clk = 1'b0;
  logic rst_n, cfg_ras_only, self_ref_req, ref_gnt;
  logic [1:0] cfg_rows;
  logic acc_ras_n, acc_lcas_n, acc_ucas_n, acc_we_n, acc_dq_oe;
  logic [ROW_W-1:0] acc_addr, addr;
  logic ref_req, ras_n, lcas_n, ucas_n, we_n, dq_oe;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dram_refresh_sched #(.ROW_W(ROW_W), .INTERVAL(INTERVAL), .T_CSR(T_CSR), .T_RAS(T_RAS),
                       .T_RP(T_RP), .MAX_PEND(MAX_PEND)) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .cfg_ras_only(cfg_ras_only), .cfg_rows(cfg_rows),
    .self_ref_req(self_ref_req), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .acc_ras_n(acc_ras_n), .acc_lcas_n(acc_lcas_n), .acc_ucas_n(acc_ucas_n),
    .acc_we_n(acc_we_n), .acc_dq_oe(acc_dq_oe), .acc_addr(acc_addr),
    .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n), .we_n(we_n), .dq_oe(dq_oe), .addr(addr));

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] pins();
    return {ras_n, lcas_n, ucas_n, we_n, dq_oe, addr};
  endfunction

  task automatic seg(input string tag, input logic [4:0] s, input logic [ROW_W-1:0] a, input int n);
    logic [12:0] exp, bad;
    int nbad;
    exp = {s, a};
    nbad = 0;
    bad = exp;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pins() != exp) begin
        if (nbad == 0) bad = pins();
        nbad++;
      end
    end
    check(tag, int'(bad), int'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_gnt = 1'b0; self_ref_req = 1'b0;
    cfg_ras_only = 1'b0; cfg_rows = 2'd0;
    acc_ras_n = 1'b1; acc_lcas_n = 1'b1; acc_ucas_n = 1'b1; acc_we_n = 1'b1;
    acc_dq_oe = 1'b1; acc_addr = 8'h5A;
    repeat (3) @(negedge clk);
    check("R1 req in reset", int'(ref_req), 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_req_grant();
    for (int i = 0; i < INTERVAL + 20; i++) begin
      @(negedge clk);
      if (ref_req) begin
        ref_gnt = 1'b1;
        return;
      end
    end
    check("request never came", 0, 1);
  endtask

  task automatic t_interval_and_mux();
    do_reset();
    for (int k = 1; k <= INTERVAL; k++) begin
      @(negedge clk);
      if (k == 1) check("R1 req after release", int'(ref_req), 0);
      if (k == INTERVAL - 1) check("R2 req one edge early", int'(ref_req), 0);
      if (k == INTERVAL) begin
        check("R2 req at interval", int'(ref_req), 1);
        check("R3 no strobes without grant", int'(pins()), int'({5'b11111, 8'h5A}));
      end
    end
    acc_ras_n = 1'b0; acc_lcas_n = 1'b0; acc_we_n = 1'b0; acc_dq_oe = 1'b0; acc_addr = 8'hC3;
    @(negedge clk);
    check("R11 pass pattern A", int'(pins()), int'({5'b00100, 8'hC3}));
    acc_ras_n = 1'b1; acc_ucas_n = 1'b0; acc_dq_oe = 1'b1; acc_addr = 8'h3C;
    @(negedge clk);
    check("R11 pass pattern B", int'(pins()), int'({5'b10001, 8'h3C}));
    acc_lcas_n = 1'b1; acc_ucas_n = 1'b1; acc_we_n = 1'b1;
  endtask

  task automatic t_cas_first();
    cfg_ras_only = 1'b0;
    @(negedge clk);
    ref_gnt = 1'b1;
    seg("R4 cas setup", 5'b10010, '0, T_CSR);
    seg("R4 ras low", 5'b00010, '0, T_RAS);
    seg("R4 precharge", 5'b11110, '0, T_RP);
    @(negedge clk);
    check("R8 req drops after precharge", int'(ref_req), 0);
    check("R9 data hiz under grant", int'(dq_oe), 0);
    ref_gnt = 1'b0;
  endtask

  task automatic ro_once(input int row);
    wait_req_grant();
    seg($sformatf("R5 row setup row %0d", row), 5'b11110, ROW_W'(row), T_CSR);
    seg($sformatf("R5 ras low row %0d", row), 5'b01110, ROW_W'(row), T_RAS);
    seg("R5 precharge", 5'b11110, '0, T_RP);
    ref_gnt = 1'b0;
  endtask

  task automatic t_row_only();
    do_reset();
    cfg_ras_only = 1'b1;
    ro_once(0);
    ro_once(1);
    ro_once(2);
  endtask

  task automatic t_wrap(input logic [1:0] sel, input int rows);
    logic prev;
    int idx, nbad, badv, bade;
    do_reset();
    cfg_ras_only = 1'b1;
    cfg_rows = sel;
    ref_gnt = 1'b1;
    prev = 1'b1; idx = 0; nbad = 0; badv = 0; bade = 0;
    while (idx < rows + 2) begin
      @(negedge clk);
      if (prev && !ras_n) begin
        if (int'(addr) != idx % rows) begin
          if (nbad == 0) begin badv = int'(addr); bade = idx % rows; end
          nbad++;
        end
        idx++;
      end
      prev = ras_n;
    end
    check($sformatf("R6 row sequence wrap at %0d", rows), badv, bade);
    check($sformatf("R6 mismatches at %0d", rows), nbad, 0);
    ref_gnt = 1'b0;
  endtask

  task automatic t_backlog();
    logic prev;
    int falls, last, gapbad, cyc;
    do_reset();
    repeat (10 * INTERVAL + 5) @(negedge clk);
    check("R7 backlog requested", int'(ref_req), 1);
    ref_gnt = 1'b1;
    prev = 1'b1; falls = 0; last = 0; gapbad = 0; cyc = 0;
    while (cyc < 40 * SEQ) begin
      @(negedge clk);
      cyc++;
      if (!ref_req) break;
      if (prev && !ras_n) begin
        if (falls > 0 && cyc - last != SEQ) gapbad++;
        last = cyc;
        falls++;
      end
      prev = ras_n;
    end
    check("R7 saturated count issued", falls, MAX_PEND);
    check("R7 back to back spacing", gapbad, 0);
    ref_gnt = 1'b0;
  endtask

  task automatic t_self();
    do_reset();
    cfg_ras_only = 1'b1;
    @(negedge clk);
    self_ref_req = 1'b1;
    ref_gnt = 1'b1;
    seg("R10 self cas first", 5'b10010, '0, T_CSR);
    seg("R10 self held", 5'b00010, '0, 3 * INTERVAL);
    self_ref_req = 1'b0;
    seg("R10 self exit precharge", 5'b11110, '0, T_RP);
    @(negedge clk);
    check("R10 no pending after self", int'(ref_req), 0);
    ref_gnt = 1'b0;
  endtask

  initial begin
    t_interval_and_mux();
    t_cas_first();
    t_row_only();
    t_wrap(2'd2, 64);
    t_wrap(2'd1, 128);
    t_backlog();
    t_self();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule